// File: doc/BRIEF.md
# Vector Three-Operand Integer Instruction Classifier

This block looks at one 32-bit instruction word from the vector integer group in which all three register operands share one element size. It pulls out the three register indices, the element-size code, the variant bit, the full-width bit and the five-bit operation code. It then sorts the word into exactly one of three classes: reserved (the encoding must raise an undefined-instruction trap), known but not handled by the attached datapath, or executable. The sorting rules depend on the operation code together with the element size, the full-width bit and the variant bit.

The decoded result is available combinationally in the same cycle. A second copy passes through a one-entry output register with a valid/ready handshake, for a following execution stage. The caller is expected to have already matched the fixed bits that select this group.

Top module: `simd3_decoder`

## Requirements
- R1: Fields are taken from the word at these bit positions: full-width flag at bit 30, variant flag at bit 29, size at bits 23:22, operation code at bits 15:11, second source index at bits 20:16, first source index at bits 9:5, destination index at bits 4:0.
- R2: Operation code 0x13 with the variant flag set and a size other than 0 is classed reserved.
- R3: Operation codes 0x0, 0x2, 0x4, 0xC, 0xD, 0xE, 0xF, 0x12 and 0x13 are classed reserved when size is 3. When R2 does not apply, they are otherwise classed not-handled.
- R4: Operation codes 0x1, 0x5, 0x8, 0x9, 0xA and 0xB are classed reserved when size is 3 and the full-width flag is 0. Otherwise they are classed not-handled.
- R5: Operation code 0x16 is classed reserved when size is 0 or 3. Otherwise it is classed not-handled.
- R6: Every other operation code (including 0x6, 0x7, 0x10, 0x11 and the rest of 0x14 to 0x1F) is classed reserved when size is 3 and the full-width flag is 0. Otherwise it is classed executable.
- R7: The class output is one-hot with bit 0 = reserved, bit 1 = not-handled and bit 2 = executable. Exactly one bit is set for every input word.
- R8: When in_valid and out_ready are both high at a rising clock edge, the registered outputs take the decoded values of that word and out_valid is high after the edge.
- R9: When out_valid is high and out_ready is low, out_valid and all registered outputs keep their values across the clock edge.
- R10: While rst_n is low, out_valid is low.
- R11: When out_ready is high and in_valid is low at a rising clock edge, out_valid is low after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn | input | 32 | Instruction word |
| in_valid | input | 1 | insn holds a word to capture |
| out_ready | input | 1 | Next stage accepts the registered result |
| dec_rd | output | 5 | Destination index (combinational) |
| dec_rn | output | 5 | First source index (combinational) |
| dec_rm | output | 5 | Second source index (combinational) |
| dec_size | output | 2 | Element-size code (combinational) |
| dec_var | output | 1 | Variant flag (combinational) |
| dec_full | output | 1 | Full-width flag (combinational) |
| dec_opc | output | 5 | Operation code (combinational) |
| dec_class | output | 3 | One-hot class (combinational) |
| out_valid | output | 1 | Registered result is valid |
| reg_rd | output | 5 | Registered destination index |
| reg_rn | output | 5 | Registered first source index |
| reg_rm | output | 5 | Registered second source index |
| reg_size | output | 2 | Registered element-size code |
| reg_var | output | 1 | Registered variant flag |
| reg_full | output | 1 | Registered full-width flag |
| reg_opc | output | 5 | Registered operation code |
| reg_class | output | 3 | Registered one-hot class |

## Verification
The combinational fields and class are due in the same cycle the word is applied. The registered copy and out_valid are due one rising edge after the capture, hold or drain condition is sampled. The bench drives inputs on the falling edge. At the following falling edge it compares the combinational outputs against that word and compares the registered outputs against a model that is updated on the rising edge in between. As a result, every result is sampled exactly one half-cycle after it becomes due and never at an edge.

// File: rtl/simd3_pkg.sv
package simd3_pkg;
  localparam int INSN_W = 32;
  localparam int IDX_W  = 5;
  localparam int SZ_W   = 2;
  localparam int OPC_W  = 5;
  localparam int CLS_W  = 3;

  localparam int CLS_RSV  = 0;
  localparam int CLS_NIMP = 1;
  localparam int CLS_EXEC = 2;

  typedef struct packed {
    logic [IDX_W-1:0] rd;
    logic [IDX_W-1:0] rn;
    logic [IDX_W-1:0] rm;
    logic [SZ_W-1:0]  size;
    logic             var_u;
    logic             full;
    logic [OPC_W-1:0] opc;
    logic [CLS_W-1:0] cls;
  } simd3_dec_t;
endpackage

// File: rtl/simd3_fields.sv
module simd3_fields
  import simd3_pkg::*;
#(
  parameter int FULL_BIT = 30,
  parameter int VAR_BIT  = 29,
  parameter int SZ_LSB   = 22,
  parameter int RM_LSB   = 16,
  parameter int OPC_LSB  = 11,
  parameter int RN_LSB   = 5,
  parameter int RD_LSB   = 0
) (
  input  logic [INSN_W-1:0] insn,
  output logic [IDX_W-1:0]  rd,
  output logic [IDX_W-1:0]  rn,
  output logic [IDX_W-1:0]  rm,
  output logic [SZ_W-1:0]   size,
  output logic              var_u,
  output logic              full,
  output logic [OPC_W-1:0]  opc
);
  assign rd    = insn[RD_LSB  +: IDX_W];
  assign rn    = insn[RN_LSB  +: IDX_W];
  assign rm    = insn[RM_LSB  +: IDX_W];
  assign size  = insn[SZ_LSB  +: SZ_W];
  assign opc   = insn[OPC_LSB +: OPC_W];
  assign var_u = insn[VAR_BIT];
  assign full  = insn[FULL_BIT];
endmodule

// File: rtl/simd3_classify.sv
module simd3_classify
  import simd3_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  input  logic [SZ_W-1:0]  size,
  input  logic             var_u,
  input  logic             full,
  output logic [CLS_W-1:0] cls
);
  localparam int NOPC = 1 << OPC_W;
  // membership masks indexed by operation code
  localparam logic [NOPC-1:0] ELEM_LIMITED = NOPC'(32'h000C_F015);
  localparam logic [NOPC-1:0] WIDE_LIMITED = NOPC'(32'h0000_0F22);
  localparam logic [OPC_W-1:0] OPC_MULPOLY = OPC_W'(5'h13);
  localparam logic [OPC_W-1:0] OPC_DBLHIGH = OPC_W'(5'h16);
  localparam logic [SZ_W-1:0]  SZ_MAX      = {SZ_W{1'b1}};

  logic sz_top, sz_zero, narrow_top;

  assign sz_top     = (size == SZ_MAX);
  assign sz_zero    = (size == '0);
  assign narrow_top = sz_top && !full;

  always_comb begin
    cls = '0;
    if (opc == OPC_MULPOLY && var_u && !sz_zero) begin
      cls[CLS_RSV] = 1'b1;
    end else if (ELEM_LIMITED[opc]) begin
      if (sz_top) cls[CLS_RSV]  = 1'b1;
      else        cls[CLS_NIMP] = 1'b1;
    end else if (WIDE_LIMITED[opc]) begin
      if (narrow_top) cls[CLS_RSV]  = 1'b1;
      else            cls[CLS_NIMP] = 1'b1;
    end else if (opc == OPC_DBLHIGH) begin
      if (sz_top || sz_zero) cls[CLS_RSV]  = 1'b1;
      else                   cls[CLS_NIMP] = 1'b1;
    end else begin
      if (narrow_top) cls[CLS_RSV]  = 1'b1;
      else            cls[CLS_EXEC] = 1'b1;
    end
  end
endmodule

// File: rtl/simd3_slice.sv
module simd3_slice #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  logic         vld_q, vld_d;
  logic         load_en;
  logic [W-1:0] dat_q;

  assign load_en = in_valid && out_ready;

  always_comb begin
    vld_d = vld_q;
    if (out_ready) vld_d = in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (load_en) dat_q <= in_data;
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;
endmodule

// File: rtl/simd3_decoder.sv
module simd3_decoder
  import simd3_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INSN_W-1:0] insn,
  input  logic              in_valid,
  input  logic              out_ready,
  output logic [IDX_W-1:0]  dec_rd,
  output logic [IDX_W-1:0]  dec_rn,
  output logic [IDX_W-1:0]  dec_rm,
  output logic [SZ_W-1:0]   dec_size,
  output logic              dec_var,
  output logic              dec_full,
  output logic [OPC_W-1:0]  dec_opc,
  output logic [CLS_W-1:0]  dec_class,
  output logic              out_valid,
  output logic [IDX_W-1:0]  reg_rd,
  output logic [IDX_W-1:0]  reg_rn,
  output logic [IDX_W-1:0]  reg_rm,
  output logic [SZ_W-1:0]   reg_size,
  output logic              reg_var,
  output logic              reg_full,
  output logic [OPC_W-1:0]  reg_opc,
  output logic [CLS_W-1:0]  reg_class
);
  localparam int DW = $bits(simd3_dec_t);

  simd3_dec_t now_d, held_q;

  simd3_fields u_fields (
    .insn  (insn),
    .rd    (dec_rd),
    .rn    (dec_rn),
    .rm    (dec_rm),
    .size  (dec_size),
    .var_u (dec_var),
    .full  (dec_full),
    .opc   (dec_opc)
  );

  simd3_classify u_class (
    .opc   (dec_opc),
    .size  (dec_size),
    .var_u (dec_var),
    .full  (dec_full),
    .cls   (dec_class)
  );

  always_comb begin
    now_d.rd    = dec_rd;
    now_d.rn    = dec_rn;
    now_d.rm    = dec_rm;
    now_d.size  = dec_size;
    now_d.var_u = dec_var;
    now_d.full  = dec_full;
    now_d.opc   = dec_opc;
    now_d.cls   = dec_class;
  end

  simd3_slice #(.W(DW)) u_slice (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (now_d),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (held_q)
  );

  assign reg_rd    = held_q.rd;
  assign reg_rn    = held_q.rn;
  assign reg_rm    = held_q.rm;
  assign reg_size  = held_q.size;
  assign reg_var   = held_q.var_u;
  assign reg_full  = held_q.full;
  assign reg_opc   = held_q.opc;
  assign reg_class = held_q.cls;
endmodule

// File: rtl/simd3_decoder_chk.sv
module simd3_decoder_chk
  import simd3_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             out_ready,
  input logic [SZ_W-1:0]  dec_size,
  input logic             dec_var,
  input logic             dec_full,
  input logic [OPC_W-1:0] dec_opc,
  input logic [CLS_W-1:0] dec_class,
  input logic             out_valid,
  input logic [IDX_W-1:0] reg_rd,
  input logic [OPC_W-1:0] reg_opc,
  input logic [CLS_W-1:0] reg_class
);
  // R7
  class_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dec_class) == 1);

  // R5
  dblhigh_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_opc == 5'h16 && (dec_size == 2'd0 || dec_size == 2'd3)) |-> dec_class[CLS_RSV]);

  // R2
  mulpoly_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_opc == 5'h13 && dec_var && dec_size != 2'd0) |-> dec_class[CLS_RSV]);

  // R6
  exec_narrow_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_class[CLS_EXEC]) |-> !(dec_size == 2'd3 && !dec_full));

  // R8
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && out_ready) |=> (out_valid && reg_opc == $past(dec_opc) && reg_class == $past(dec_class)));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(reg_rd) && $stable(reg_opc) && $stable(reg_class)));

  // R11
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && !in_valid) |=> !out_valid);

  // R10
  always_comb begin
    if (!rst_n) reset_idle_chk: assert (!out_valid);
  end
endmodule

bind simd3_decoder simd3_decoder_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .out_ready (out_ready),
  .dec_size  (dec_size),
  .dec_var   (dec_var),
  .dec_full  (dec_full),
  .dec_opc   (dec_opc),
  .dec_class (dec_class),
  .out_valid (out_valid),
  .reg_rd    (reg_rd),
  .reg_opc   (reg_opc),
  .reg_class (reg_class)
);

// File: tb/simd3_decoder_test.sv
module simd3_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] insn = '0;
  logic        in_valid = 1'b0;
  logic        out_ready = 1'b0;
  logic [4:0]  dec_rd, dec_rn, dec_rm, dec_opc, reg_rd, reg_rn, reg_rm, reg_opc;
  logic [1:0]  dec_size, reg_size;
  logic        dec_var, dec_full, out_valid, reg_var, reg_full;
  logic [2:0]  dec_class, reg_class;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  simd3_decoder uut (
    .clk(clk), .rst_n(rst_n), .insn(insn), .in_valid(in_valid), .out_ready(out_ready),
    .dec_rd(dec_rd), .dec_rn(dec_rn), .dec_rm(dec_rm), .dec_size(dec_size),
    .dec_var(dec_var), .dec_full(dec_full), .dec_opc(dec_opc), .dec_class(dec_class),
    .out_valid(out_valid), .reg_rd(reg_rd), .reg_rn(reg_rn), .reg_rm(reg_rm),
    .reg_size(reg_size), .reg_var(reg_var), .reg_full(reg_full), .reg_opc(reg_opc),
    .reg_class(reg_class)
  );

  // class encoding: 1 = reserved, 2 = not-handled, 4 = executable
  function automatic logic [2:0] ref_class(input logic [31:0] w, output string tag);
    int op, sz;
    bit u, q;
    op = int'(w[15:11]); sz = int'(w[23:22]); u = w[29]; q = w[30];
    if (op == 'h13 && u && sz != 0) begin
      tag = "R2"; return 3'b001;
    end
    if (op inside {'h0, 'h2, 'h4, 'hC, 'hD, 'hE, 'hF, 'h12, 'h13}) begin
      tag = "R3"; return (sz == 3) ? 3'b001 : 3'b010;
    end
    if (op inside {'h1, 'h5, 'h8, 'h9, 'hA, 'hB}) begin
      tag = "R4"; return (sz == 3 && !q) ? 3'b001 : 3'b010;
    end
    if (op == 'h16) begin
      tag = "R5"; return (sz == 0 || sz == 3) ? 3'b001 : 3'b010;
    end
    tag = "R6";
    return (sz == 3 && !q) ? 3'b001 : 3'b100;
  endfunction

  function automatic logic [26:0] ref_bus(input logic [31:0] w);
    string t;
    logic [2:0] c;
    c = ref_class(w, t);
    return {w[4:0], w[9:5], w[20:16], w[23:22], w[29], w[30], w[15:11], c};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model of the output register
  bit          m_valid;
  logic [26:0] m_data;
  string       m_tag;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_tag   <= "R10";
    end else if (out_ready) begin
      m_valid <= in_valid;
      m_tag   <= in_valid ? "R8" : "R11";
      if (in_valid) m_data <= ref_bus(insn);
    end else begin
      m_tag <= "R9";
    end
  end

  task automatic compare_now();
    string t;
    logic [2:0] ec;
    logic [26:0] got;
    ec = ref_class(insn, t);
    check(dec_class == ec, t, 32'(dec_class), 32'(ec));
    check($countones(dec_class) == 1, "R7", 32'(dec_class), 32'(ec));
    // R1 field positions
    check({dec_rd, dec_rn, dec_rm, dec_size, dec_var, dec_full, dec_opc} ==
          {insn[4:0], insn[9:5], insn[20:16], insn[23:22], insn[29], insn[30], insn[15:11]},
          "R1", 32'({dec_rd, dec_rn, dec_rm, dec_size, dec_var, dec_full, dec_opc}),
          32'({insn[4:0], insn[9:5], insn[20:16], insn[23:22], insn[29], insn[30], insn[15:11]}));
    check(out_valid == m_valid, m_tag, 32'(out_valid), 32'(m_valid));
    if (m_valid) begin
      got = {reg_rd, reg_rn, reg_rm, reg_size, reg_var, reg_full, reg_opc, reg_class};
      check(got == m_data, m_tag, 32'(got), 32'(m_data));
    end
  endtask

  task automatic step(input logic [31:0] w, input bit iv, input bit rdy);
    @(negedge clk);
    compare_now();
    insn = w; in_valid = iv; out_ready = rdy;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(out_valid == 1'b0, "R10", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    // exhaustive control combinations, random register indices and handshake
    for (int pass = 0; pass < 3; pass++) begin
      for (int k = 0; k < 512; k++) begin
        w = $urandom;
        w[15:11] = 5'(k & 31);
        w[23:22] = 2'((k >> 5) & 3);
        w[29]    = k[7];
        w[30]    = k[8];
        step(w, ($urandom % 4) != 0, ($urandom % 10) < 7);
      end
    end
    // directed: capture, long stall with changing input, then drain (R8, R9, R11)
    step(32'h4020_3C41, 1'b1, 1'b1);
    for (int i = 0; i < 5; i++) step($urandom, 1'b1, 1'b0);
    step(32'h0000_0000, 1'b0, 1'b1);
    step(32'h0000_0000, 1'b0, 1'b1);
    // directed boundaries: 0x16 with size 1, 0x13 unsigned size 0, size 3 narrow add
    step(32'h0060_B000, 1'b1, 1'b1);
    step(32'h2000_9800, 1'b1, 1'b1);
    step(32'h00C0_8000, 1'b1, 1'b1);
    step(32'h40C0_8000, 1'b1, 1'b1);
    step(32'h0000_0000, 1'b0, 1'b1);
    step(32'h0000_0000, 1'b0, 1'b1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule